// File: doc/BRIEF.md
# Shift-and-Flag Arithmetic Logic Unit

This block is the execute stage of a small integer core. Each clock cycle it takes one operation: an opcode, two 32-bit operands, a shift kind and amount for the second operand, a request to update the condition flags, and the carry flag the core currently holds. The second operand first passes through a barrel shifter. The arithmetic or logic unit then combines it with the first operand. The result, a write-enable for the destination register, and the four condition flags (negative, zero, carry, overflow) are registered on the next rising edge.

Comparisons and tests exist only to produce flags. They always update the flags and never request a register write. Add and subtract derive carry and overflow from the adder. Moves and bitwise operations take carry from the shifter and keep the old overflow flag. Instruction decode, the register file, multiply and memory access belong to other blocks.

The block has no control state machine. Every operation takes the same path: operand shifter, then datapath, then flag/write decision, then a single output register stage.

Top module: `alu_nzcv_core`

## Requirements
- R1: While `rst_n` is low, `result_o`, `wr_en_o` and `flags_o` are all zero. The flag bit order is [3]=N, [2]=Z, [1]=C, [0]=V.
- R2: Opcode 1 (add) and opcode 4 (compare-negative) compute A+B. With flags updated: C is set when the unsigned sum is 2^32 or more, and V is set when both operands share a sign and the sum's sign differs.
- R3: Opcode 2 (subtract) and opcode 3 (compare) compute A-B. C is set when no borrow occurs (A >= B unsigned). V is set when the operand signs differ and the result's sign differs from A.
- R4: Opcodes 0 (move: B), 5 (A AND B), 6 (A OR B), 7 (A XOR B), 8 (A AND NOT B) and 9 (A OR NOT B) produce their bitwise results and assert `wr_en_o`. With flags updated, C takes the shifter's carry-out.
- R5: Shift kinds 0 (logical left), 1 (logical right), 2 (arithmetic right) and 3 (rotate right) move operand B by `sh_amt_i`. The shifter carry is the last bit shifted out; for rotate it is the new bit 31. Kinds 5 to 7 leave B unchanged.
- R6: Shift kind 4 (rotate right through carry) gives {carry_i, B[31:1]} whatever the amount, with shifter carry B[0].
- R7: A shift amount of zero, or an unchanged kind, leaves B as it is and passes `carry_i` through as the shifter carry.
- R8: When `set_flags_i` is low, opcodes 0, 1, 2 and 5 to 9 leave `flags_o` unchanged.
- R9: Opcodes 3, 4, 10 (test: A AND B) and 11 (test-equivalence: A XOR B) always update flags and deassert `wr_en_o`. Tests set N and Z from the result and C from the shifter.
- R10: Move, bitwise and test operations never change V.
- R11: Opcodes 12 to 15 deassert `wr_en_o`, drive `result_o` to zero and leave the flags unchanged.
- R12: Each operation's result, write-enable and flags appear at the outputs after the first rising edge that samples its inputs.
- R13: With flags updated, N equals result bit 31 and Z is set exactly when the result is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand, before shifting |
| sh_kind_i | input | 3 | Shift kind applied to the second operand |
| sh_amt_i | input | 5 | Shift amount |
| set_flags_i | input | 1 | Request a flag update |
| carry_i | input | 1 | Carry flag currently held by the core |
| result_o | output | 32 | Registered result |
| wr_en_o | output | 1 | Registered destination write-enable |
| flags_o | output | 4 | Registered N, Z, C, V |

## Verification
Every result, write-enable and flag is due exactly one rising edge after the operation is applied. No output has a longer latency. The bench applies one operation per cycle, one time unit after a rising edge. It waits for the next rising edge and compares all three outputs one time unit later, well clear of both edges. The reference model then advances its own copy of the flags, so that a wrong flag, whether held or updated, shows up at the very operation that caused it.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_MOV = 4'd0,
        OP_ADD = 4'd1,
        OP_SUB = 4'd2,
        OP_CMP = 4'd3,
        OP_CMN = 4'd4,
        OP_AND = 4'd5,
        OP_ORR = 4'd6,
        OP_EOR = 4'd7,
        OP_BIC = 4'd8,
        OP_ORN = 4'd9,
        OP_TST = 4'd10,
        OP_TEQ = 4'd11
    } alu_op_e;

    typedef enum logic [2:0] {
        SH_LSL = 3'd0,
        SH_LSR = 3'd1,
        SH_ASR = 3'd2,
        SH_ROR = 3'd3,
        SH_RRX = 3'd4
    } shift_kind_e;

    // Source of the C and V flags for an operation
    typedef enum logic [1:0] {
        FSRC_NONE  = 2'd0,
        FSRC_ARITH = 2'd1,
        FSRC_LOGIC = 2'd2
    } flag_src_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

endpackage

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   b_i,
    input  logic [2:0]     kind_i,
    input  logic [SHW-1:0] amt_i,
    input  logic           carry_i,
    output logic [W-1:0]   b_o,
    output logic           carry_o
);
    import alu_pkg::*;

    localparam logic [SHW:0] W_L = (SHW+1)'(W);

    logic [W:0]        left_ext;
    logic [W:0]        right_ext;
    logic signed [W:0] sright_ext;
    logic [SHW:0]      back_amt;
    logic [W-1:0]      rot_val;

    always_comb begin
        left_ext   = {1'b0, b_i} << amt_i;
        right_ext  = {b_i, 1'b0} >> amt_i;
        sright_ext = $signed({b_i, 1'b0}) >>> amt_i;
        back_amt   = W_L - {1'b0, amt_i};
        rot_val    = (b_i >> amt_i) | (b_i << back_amt);

        b_o     = b_i;
        carry_o = carry_i;
        case (kind_i)
            SH_LSL: begin
                if (amt_i != '0) begin
                    b_o     = left_ext[W-1:0];
                    carry_o = left_ext[W];
                end
            end
            SH_LSR: begin
                if (amt_i != '0) begin
                    b_o     = right_ext[W:1];
                    carry_o = right_ext[0];
                end
            end
            SH_ASR: begin
                if (amt_i != '0) begin
                    b_o     = sright_ext[W:1];
                    carry_o = sright_ext[0];
                end
            end
            SH_ROR: begin
                if (amt_i != '0) begin
                    b_o     = rot_val;
                    carry_o = rot_val[W-1];
                end
            end
            SH_RRX: begin
                b_o     = {carry_i, b_i[W-1:1]};
                carry_o = b_i[0];
            end
            default: begin
                b_o     = b_i;
                carry_o = carry_i;
            end
        endcase
    end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath #(
    parameter int W = 32
) (
    input  logic [3:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sh_carry_i,
    output logic [W-1:0] res_o,
    output logic         c_o,
    output logic         v_o,
    output logic [1:0]   fsrc_o
);
    import alu_pkg::*;

    localparam logic [W:0] ONE_X = (W+1)'(1);

    logic [W:0] sum_x;
    logic [W:0] diff_x;
    logic       add_ovf;
    logic       sub_ovf;

    always_comb begin
        sum_x   = {1'b0, a_i} + {1'b0, b_i};
        diff_x  = {1'b0, a_i} + {1'b0, ~b_i} + ONE_X;
        add_ovf = (a_i[W-1] == b_i[W-1]) && (sum_x[W-1] != a_i[W-1]);
        sub_ovf = (a_i[W-1] != b_i[W-1]) && (diff_x[W-1] != a_i[W-1]);
    end

    always_comb begin
        res_o  = '0;
        c_o    = sh_carry_i;
        v_o    = 1'b0;
        fsrc_o = FSRC_NONE;
        case (op_i)
            OP_ADD, OP_CMN: begin
                res_o  = sum_x[W-1:0];
                c_o    = sum_x[W];
                v_o    = add_ovf;
                fsrc_o = FSRC_ARITH;
            end
            OP_SUB, OP_CMP: begin
                res_o  = diff_x[W-1:0];
                c_o    = diff_x[W];
                v_o    = sub_ovf;
                fsrc_o = FSRC_ARITH;
            end
            OP_MOV: begin
                res_o  = b_i;
                fsrc_o = FSRC_LOGIC;
            end
            OP_AND, OP_TST: begin
                res_o  = a_i & b_i;
                fsrc_o = FSRC_LOGIC;
            end
            OP_ORR: begin
                res_o  = a_i | b_i;
                fsrc_o = FSRC_LOGIC;
            end
            OP_EOR, OP_TEQ: begin
                res_o  = a_i ^ b_i;
                fsrc_o = FSRC_LOGIC;
            end
            OP_BIC: begin
                res_o  = a_i & ~b_i;
                fsrc_o = FSRC_LOGIC;
            end
            OP_ORN: begin
                res_o  = a_i | ~b_i;
                fsrc_o = FSRC_LOGIC;
            end
            default: begin
                res_o  = '0;
                fsrc_o = FSRC_NONE;
            end
        endcase
    end

endmodule

// File: rtl/alu_flag_ctrl.sv
module alu_flag_ctrl #(
    parameter int W = 32
) (
    input  logic [3:0]   op_i,
    input  logic         set_flags_i,
    input  logic [W-1:0] res_i,
    input  logic         c_i,
    input  logic         v_i,
    input  logic [1:0]   fsrc_i,
    input  logic [3:0]   flags_cur_i,
    output logic [3:0]   flags_nxt_o,
    output logic         wr_o
);
    import alu_pkg::*;

    logic  flags_only;
    logic  upd;
    nzcv_t cur;
    nzcv_t nxt;

    always_comb begin
        cur = nzcv_t'(flags_cur_i);
        case (op_i)
            OP_CMP, OP_CMN, OP_TST, OP_TEQ: flags_only = 1'b1;
            default:                        flags_only = 1'b0;
        endcase

        wr_o = (fsrc_i != FSRC_NONE) && !flags_only;
        upd  = (fsrc_i != FSRC_NONE) && (set_flags_i || flags_only);

        nxt = cur;
        if (upd) begin
            nxt.n = res_i[W-1];
            nxt.z = (res_i == '0);
            nxt.c = c_i;
            nxt.v = (fsrc_i == FSRC_ARITH) ? v_i : cur.v;
        end
        flags_nxt_o = nxt;
    end

endmodule

// File: rtl/alu_nzcv_core.sv
module alu_nzcv_core #(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [3:0]     op_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic [2:0]     sh_kind_i,
    input  logic [SHW-1:0] sh_amt_i,
    input  logic           set_flags_i,
    input  logic           carry_i,
    output logic [W-1:0]   result_o,
    output logic           wr_en_o,
    output logic [3:0]     flags_o
);

    logic [W-1:0] b_sh;
    logic         sh_carry;
    logic [W-1:0] res_d;
    logic         c_d;
    logic         v_d;
    logic [1:0]   fsrc_d;
    logic [3:0]   flags_d;
    logic         wr_d;

    alu_shifter #(.W(W), .SHW(SHW)) u_shift (
        .b_i     (b_i),
        .kind_i  (sh_kind_i),
        .amt_i   (sh_amt_i),
        .carry_i (carry_i),
        .b_o     (b_sh),
        .carry_o (sh_carry)
    );

    alu_datapath #(.W(W)) u_dp (
        .op_i       (op_i),
        .a_i        (a_i),
        .b_i        (b_sh),
        .sh_carry_i (sh_carry),
        .res_o      (res_d),
        .c_o        (c_d),
        .v_o        (v_d),
        .fsrc_o     (fsrc_d)
    );

    alu_flag_ctrl #(.W(W)) u_flags (
        .op_i        (op_i),
        .set_flags_i (set_flags_i),
        .res_i       (res_d),
        .c_i         (c_d),
        .v_i         (v_d),
        .fsrc_i      (fsrc_d),
        .flags_cur_i (flags_o),
        .flags_nxt_o (flags_d),
        .wr_o        (wr_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o <= '0;
            wr_en_o  <= 1'b0;
            flags_o  <= '0;
        end else begin
            result_o <= res_d;
            wr_en_o  <= wr_d;
            flags_o  <= flags_d;
        end
    end

endmodule

// File: rtl/alu_nzcv_chk.sv
module alu_nzcv_chk #(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input logic           clk,
    input logic           rst_n,
    input logic [3:0]     op_i,
    input logic           set_flags_i,
    input logic [W-1:0]   result_o,
    input logic           wr_en_o,
    input logic [3:0]     flags_o
);

    logic is_cmp_tst;
    logic is_write_op;
    logic keeps_v;

    always_comb begin
        is_cmp_tst  = (op_i == 4'd3) || (op_i == 4'd4) || (op_i == 4'd10) || (op_i == 4'd11);
        is_write_op = (op_i <= 4'd2) || ((op_i >= 4'd5) && (op_i <= 4'd9));
        keeps_v     = (op_i == 4'd0) || ((op_i >= 4'd5) && (op_i <= 4'd11));
    end

    // R9: compares and tests never request a write
    a_r9_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmp_tst |=> !wr_en_o);

    // R8: flags hold without a set request
    a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (is_write_op && !set_flags_i) |=> $stable(flags_o));

    // R10: overflow untouched by moves, bitwise ops and tests
    a_r10_v_kept: assert property (@(posedge clk) disable iff (!rst_n)
        keeps_v |=> (flags_o[0] == $past(flags_o[0])));

    // R11: undefined opcodes do nothing visible
    a_r11_undef_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 4'd12) |=> (!wr_en_o && $stable(flags_o) && (result_o == '0)));

    // R13: N and Z follow the written result
    a_r13_nz_match: assert property (@(posedge clk) disable iff (!rst_n)
        (is_write_op && set_flags_i) |=>
            ((flags_o[3] == result_o[W-1]) && (flags_o[2] == (result_o == '0))));

    // R4: writing opcodes raise the write-enable
    a_r4_write_en: assert property (@(posedge clk) disable iff (!rst_n)
        is_write_op |=> wr_en_o);

endmodule

bind alu_nzcv_core alu_nzcv_chk #(.W(W), .SHW(SHW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op_i),
    .set_flags_i (set_flags_i),
    .result_o    (result_o),
    .wr_en_o     (wr_en_o),
    .flags_o     (flags_o)
);

// File: tb/tb_alu_nzcv_core.sv
`timescale 1ns/1ps
module tb_alu_nzcv_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = 4'd15;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [2:0]  sk = '0;
    logic [4:0]  amt = '0;
    logic        sf = 1'b0;
    logic        cin = 1'b0;
    logic [31:0] result;
    logic        wr_en;
    logic [3:0]  flags;

    int n_checks = 0;
    int n_fail   = 0;
    logic [3:0] mflags = 4'h0;

    always #2.5 clk = ~clk;

    alu_nzcv_core dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .a_i(a), .b_i(b),
        .sh_kind_i(sk), .sh_amt_i(amt), .set_flags_i(sf), .carry_i(cin),
        .result_o(result), .wr_en_o(wr_en), .flags_o(flags)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Independent reference: shifter
    function automatic void ref_shift(input logic [31:0] bv, input logic [2:0] k,
                                      input logic [4:0] n, input logic ci,
                                      output logic [31:0] bo, output logic co);
        logic [63:0] dbl;
        bo = bv; co = ci;
        if (k == 3'd4) begin
            bo = {ci, bv[31:1]}; co = bv[0];
        end else if (n != 0 && k <= 3'd3) begin
            case (k)
                3'd0: begin bo = bv << n; co = bv[32 - int'(n)]; end
                3'd1: begin bo = bv >> n; co = bv[int'(n) - 1]; end
                3'd2: begin bo = $unsigned($signed(bv) >>> n); co = bv[int'(n) - 1]; end
                default: begin dbl = {bv, bv} >> n; bo = dbl[31:0]; co = bo[31]; end
            endcase
        end
    endfunction

    // Independent reference: whole operation
    function automatic void ref_op(input logic [3:0] o, input logic [31:0] av,
                                   input logic [31:0] bv, input logic [2:0] k,
                                   input logic [4:0] n, input logic s, input logic ci,
                                   input logic [3:0] fl,
                                   output logic [31:0] r, output logic w,
                                   output logic [3:0] fo);
        logic [31:0] bs;
        logic sc, c, v, ar, upd;
        logic [63:0] wide;
        ref_shift(bv, k, n, ci, bs, sc);
        r = 32'h0; c = sc; v = fl[0]; ar = 1'b0; w = 1'b0; upd = 1'b0;
        case (o)
            4'd1, 4'd4: begin
                wide = {32'h0, av} + {32'h0, bs};
                r = wide[31:0]; c = wide[32] ; ar = 1'b1;
                v = ($signed(av) + 64'sd0 + $signed(bs)) > 64'sh7FFFFFFF ||
                    (64'sd0 + $signed(av) + $signed(bs)) < -64'sd2147483648;
            end
            4'd2, 4'd3: begin
                r = av - bs; c = (av >= bs); ar = 1'b1;
                v = (64'sd0 + $signed(av) - $signed(bs)) > 64'sh7FFFFFFF ||
                    (64'sd0 + $signed(av) - $signed(bs)) < -64'sd2147483648;
            end
            4'd0: r = bs;
            4'd5, 4'd10: r = av & bs;
            4'd6: r = av | bs;
            4'd7, 4'd11: r = av ^ bs;
            4'd8: r = av & ~bs;
            4'd9: r = av | ~bs;
            default: r = 32'h0;
        endcase
        if (o <= 4'd11) begin
            w   = !(o == 4'd3 || o == 4'd4 || o == 4'd10 || o == 4'd11);
            upd = s || !w;
        end
        fo = fl;
        if (upd) fo = {r[31], (r == 32'h0), c, ar ? v : fl[0]};
    endfunction

    function automatic string tag_of(input logic [3:0] o, input logic [2:0] k,
                                     input logic [4:0] n, input logic s);
        if (o >= 4'd12) return "R11";
        if (o == 4'd3 || o == 4'd4 || o >= 4'd10) return "R9";
        if (!s) return "R8";
        if (o == 4'd1) return "R2";
        if (o == 4'd2) return "R3";
        if (k == 3'd4) return "R6";
        if (n == 0 || k > 3'd4) return "R7";
        if (o == 4'd0) return "R5";
        return "R4";
    endfunction

    // Apply one op, wait one edge (R12 latency), compare all outputs
    task automatic do_op(input logic [3:0] o, input logic [31:0] av, input logic [31:0] bv,
                         input logic [2:0] k, input logic [4:0] n, input logic s,
                         input logic ci);
        logic [31:0] er; logic ew; logic [3:0] ef; string t;
        ref_op(o, av, bv, k, n, s, ci, mflags, er, ew, ef);
        t = tag_of(o, k, n, s);
        op = o; a = av; b = bv; sk = k; amt = n; sf = s; cin = ci;
        @(posedge clk); #1;
        check(t, "wr_en (R12 one-edge latency)", {31'h0, wr_en}, {31'h0, ew});
        if (ew || o >= 4'd12) check(t, "result", result, er);
        check(t, "flags NZCV (R13)", {28'h0, flags}, {28'h0, ef});
        mflags = ef;
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin : main
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd1234);
        repeat (3) @(posedge clk);
        #1;
        check("R1", "reset result", result, 32'h0);
        check("R1", "reset wr_en", {31'h0, wr_en}, 32'h0);
        check("R1", "reset flags", {28'h0, flags}, 32'h0);
        rst_n = 1'b1;

        // R2 add carry and overflow
        do_op(4'd1, 32'hFFFF_FFFF, 32'h1, 3'd0, 5'd0, 1'b1, 1'b0);
        do_op(4'd1, 32'h7FFF_FFFF, 32'h1, 3'd0, 5'd0, 1'b1, 1'b0);
        do_op(4'd4, 32'h8000_0000, 32'h8000_0000, 3'd0, 5'd0, 1'b0, 1'b0);
        // R3 subtract borrow and overflow
        do_op(4'd2, 32'd5, 32'd5, 3'd0, 5'd0, 1'b1, 1'b0);
        do_op(4'd2, 32'd3, 32'd5, 3'd0, 5'd0, 1'b1, 1'b0);
        do_op(4'd3, 32'h8000_0000, 32'h1, 3'd0, 5'd0, 1'b0, 1'b0);
        // R8 no flag change without request
        do_op(4'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd0, 5'd0, 1'b0, 1'b0);
        // R5 shifts and their carry
        do_op(4'd0, 32'h0, 32'h8000_0001, 3'd0, 5'd1, 1'b1, 1'b0);
        do_op(4'd0, 32'h0, 32'h8000_0000, 3'd1, 5'd31, 1'b1, 1'b0);
        do_op(4'd0, 32'h0, 32'h8000_0008, 3'd2, 5'd4, 1'b1, 1'b0);
        do_op(4'd0, 32'h0, 32'h1234_5680, 3'd3, 5'd8, 1'b1, 1'b0);
        // R6 rotate through carry
        do_op(4'd0, 32'h0, 32'h0000_0001, 3'd4, 5'd7, 1'b1, 1'b1);
        // R7 zero amount passes carry_i
        do_op(4'd0, 32'h0, 32'h0000_0004, 3'd0, 5'd0, 1'b1, 1'b1);
        do_op(4'd5, 32'hFFFF_FFFF, 32'h0F0F_0000, 3'd6, 5'd9, 1'b1, 1'b0);
        // R10 V survives logical op: set V, then BIC/ORN
        do_op(4'd1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 3'd0, 5'd0, 1'b1, 1'b0);
        do_op(4'd8, 32'hFFFF_00FF, 32'h0000_00F0, 3'd0, 5'd0, 1'b1, 1'b0);
        do_op(4'd9, 32'h0, 32'hFFFF_FFFF, 3'd0, 5'd0, 1'b1, 1'b0);
        // R9 tests
        do_op(4'd10, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 3'd0, 5'd0, 1'b0, 1'b0);
        do_op(4'd11, 32'h8000_0000, 32'h0000_0001, 3'd1, 5'd1, 1'b0, 1'b0);
        // R11 undefined opcodes
        do_op(4'd13, 32'h1, 32'h2, 3'd0, 5'd0, 1'b1, 1'b1);
        do_op(4'd15, 32'h0, 32'h0, 3'd0, 5'd0, 1'b1, 1'b0);

        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] ro;
            logic [31:0] ra, rb;
            logic [2:0] rk;
            ro = 4'($urandom_range(0, 15));
            ra = $urandom();
            rb = $urandom();
            if ($urandom_range(0, 7) == 0) rb = ra;
            if ($urandom_range(0, 7) == 0) ra = 32'h8000_0000 | ($urandom() & 32'h1);
            rk = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(4, 7)) : 3'($urandom_range(0, 3));
            do_op(ro, ra, rb, rk, 5'($urandom_range(0, 31)), 1'($urandom_range(0, 1)),
                  ($urandom_range(0, 3) == 0) ? ~mflags[1] : mflags[1]);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule